// File: doc/BRIEF.md
# Predecoded Hierarchical Row Decoder

This block turns a binary row address into a single active word line for a memory array that is split into several blocks. The address is cut into 2-bit pairs, and each pair is expanded into a 1-of-4 group of predecode lines. A second stage then forms every word line as the AND of one line taken from each group. The top pairs of the address choose one block. The middle pairs drive global word lines that are shared across all blocks. The lowest pair is applied only at the local word-line driver, where a global line, a block select and a low-pair line combine into one local word line.

Only the selected block may fire a local line. Every other block receives a sleep flag so that it can sit in a low-power state. While the enable input is low, no predecode line, global line or local line is active, and every block is flagged to sleep. The predecode lines are registered one clock after the address. The global lines, local lines and sleep flags are registered one clock after that. Each cycle's outputs therefore come from a single sampled address. The address is accepted on every clock edge and there is no back-pressure, so the enable acts as a qualifier and not as a handshake.

Top module: `row_decoder_hier`

## Requirements
- R1: While reset is asserted, all predecode lines, global word lines and local word lines are 0 and every block sleep flag is 1.
- R2: If `en` is high at a clock edge with address A, then after that edge predecode group g (bits 4g+3..4g of `pre_lines`) holds exactly one 1, at bit position A[2g+1:2g] inside the group.
- R3: If `en` is low at a clock edge, then `pre_lines` is all zero after that edge, and after the following edge `gwl` and `lwl` are all zero and `blk_sleep` is all ones.
- R4: If `en` is high with address A at edge k, then after edge k+1 `gwl` holds exactly one 1, at index A[7:2].
- R5: If `en` is high with address A at edge k, then after edge k+1 `lwl` holds exactly one 1, at index A (bit n of `lwl` is row n).
- R6: If `en` is high with address A at edge k, then after edge k+1 `blk_sleep` is 1 for every block except block A[9:8], which is 0.
- R7: No local word line inside a block whose sleep flag is 1 is ever active. Block b owns `lwl` bits b*256 through b*256+255.
- R8: Addresses presented on consecutive clock edges each produce their own result, in order, with a latency of two edges. No cycle ever shows more than one active local word line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Decode enable; low forces all lines off and all blocks asleep |
| row_addr | input | 10 | Binary row address; bits 9:8 select the block |
| pre_lines | output | 20 | Five registered 1-of-4 predecode groups; group g covers address bits 2g+1:2g |
| gwl | output | 64 | Registered global word lines, indexed by address bits 7:2 |
| lwl | output | 1024 | Registered local word lines, one per row |
| blk_sleep | output | 4 | Registered per-block sleep flags, 1 for each unselected block |

## Verification
The bench builds the block with its defaults: a 10-bit address and one pair of block bits, which gives four blocks of 256 rows over 64 global lines. At this size the predecode groups, the global plane and the block plane are all non-trivial. All 1024 local lines can be reached, including the last row of each block and the block boundaries, and with random addresses these are covered within a few thousand cycles. The enable is toggled both alone and in the middle of back-to-back address streams, so the all-off state is observed between one-hot results.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

  localparam int PAIR_W    = 2;
  localparam int GRP_LINES = 4;

  // Expand a 2-bit field into a 1-of-4 code.
  function automatic logic [GRP_LINES-1:0] pair_to_onehot(input logic [PAIR_W-1:0] v);
    logic [GRP_LINES-1:0] r;
    r = '0;
    r[v] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/pair_predecoder.sv
module pair_predecoder
  import rowdec_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int NGRP  = ADDR_W / PAIR_W,
  localparam int PRE_W = NGRP * GRP_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [PRE_W-1:0]  pre_q
);

  logic [PRE_W-1:0] pre_d;

  // One 2-to-4 expander per address pair, gated by the enable.
  for (genvar g = 0; g < NGRP; g++) begin : g_pair
    assign pre_d[g*GRP_LINES +: GRP_LINES] =
      en ? pair_to_onehot(addr[g*PAIR_W +: PAIR_W]) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/pair_and_plane.sv
module pair_and_plane
  import rowdec_pkg::*;
#(
  parameter int NGRP  = 5,
  parameter int LO    = 1,
  parameter int CNT   = 3,
  localparam int PRE_W = NGRP * GRP_LINES,
  localparam int NOUT  = 1 << (PAIR_W * CNT)
) (
  input  logic [PRE_W-1:0] pre,
  output logic [NOUT-1:0]  sel
);

  // Output j takes, from each used group k, the line picked by digit k of j.
  for (genvar j = 0; j < NOUT; j++) begin : g_out
    logic [CNT-1:0] term;
    for (genvar k = 0; k < CNT; k++) begin : g_term
      localparam int DIGIT = (j >> (PAIR_W * k)) % GRP_LINES;
      assign term[k] = pre[(LO + k) * GRP_LINES + DIGIT];
    end
    assign sel[j] = &term;
  end

endmodule

// File: rtl/local_wl_driver.sv
module local_wl_driver
  import rowdec_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int NGWL    = 64,
  localparam int ROWS_PER_BLK = NGWL * GRP_LINES,
  localparam int NROWS        = NUM_BLK * ROWS_PER_BLK
) (
  input  logic [NUM_BLK-1:0]   blk_sel,
  input  logic [NGWL-1:0]      gwl,
  input  logic [GRP_LINES-1:0] low_grp,
  output logic [NROWS-1:0]     lwl
);

  // Local line = block select AND global line AND low-pair line.
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    for (genvar j = 0; j < NGWL; j++) begin : g_gwl
      for (genvar k = 0; k < GRP_LINES; k++) begin : g_low
        assign lwl[b*ROWS_PER_BLK + j*GRP_LINES + k] = blk_sel[b] & gwl[j] & low_grp[k];
      end
    end
  end

endmodule

// File: rtl/row_decoder_hier.sv
module row_decoder_hier
  import rowdec_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BLK_PAIRS = 1,
  localparam int NGRP     = ADDR_W / PAIR_W,
  localparam int PRE_W    = NGRP * GRP_LINES,
  localparam int GW_PAIRS = NGRP - 1 - BLK_PAIRS,
  localparam int NGWL     = 1 << (PAIR_W * GW_PAIRS),
  localparam int NUM_BLK  = 1 << (PAIR_W * BLK_PAIRS),
  localparam int NROWS    = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] row_addr,
  output logic [PRE_W-1:0]  pre_lines,
  output logic [NGWL-1:0]   gwl,
  output logic [NROWS-1:0]  lwl,
  output logic [NUM_BLK-1:0] blk_sleep
);

  logic [NGWL-1:0]    gwl_d;
  logic [NUM_BLK-1:0] blk_d;
  logic [NROWS-1:0]   lwl_d;

  // Stage 1: pair predecode, registered.
  pair_predecoder #(.ADDR_W(ADDR_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .addr  (row_addr),
    .pre_q (pre_lines)
  );

  // Stage 2a: global plane from the middle pairs.
  pair_and_plane #(.NGRP(NGRP), .LO(1), .CNT(GW_PAIRS)) u_gplane (
    .pre (pre_lines),
    .sel (gwl_d)
  );

  // Stage 2b: block plane from the top pairs.
  pair_and_plane #(.NGRP(NGRP), .LO(NGRP - BLK_PAIRS), .CNT(BLK_PAIRS)) u_bplane (
    .pre (pre_lines),
    .sel (blk_d)
  );

  // Stage 2c: local drivers resolve the lowest pair.
  local_wl_driver #(.NUM_BLK(NUM_BLK), .NGWL(NGWL)) u_drv (
    .blk_sel (blk_d),
    .gwl     (gwl_d),
    .low_grp (pre_lines[GRP_LINES-1:0]),
    .lwl     (lwl_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gwl       <= '0;
      lwl       <= '0;
      blk_sleep <= '1;
    end else begin
      gwl       <= gwl_d;
      lwl       <= lwl_d;
      blk_sleep <= ~blk_d;
    end
  end

endmodule

// File: rtl/row_decoder_hier_chk.sv
module row_decoder_hier_chk
  import rowdec_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BLK_PAIRS = 1,
  localparam int NGRP     = ADDR_W / PAIR_W,
  localparam int PRE_W    = NGRP * GRP_LINES,
  localparam int GW_PAIRS = NGRP - 1 - BLK_PAIRS,
  localparam int NGWL     = 1 << (PAIR_W * GW_PAIRS),
  localparam int NUM_BLK  = 1 << (PAIR_W * BLK_PAIRS),
  localparam int NROWS    = 1 << ADDR_W,
  localparam int RPB      = NROWS / NUM_BLK
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic [ADDR_W-1:0]  row_addr,
  input logic [PRE_W-1:0]   pre_lines,
  input logic [NGWL-1:0]    gwl,
  input logic [NROWS-1:0]   lwl,
  input logic [NUM_BLK-1:0] blk_sleep
);

  // R2: enabled address gives one line per group
  a_r2_pre_count: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($countones(pre_lines) == NGRP));

  // R3: disabled decode clears everything
  a_r3_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ##1 ((lwl == '0) && (gwl == '0) && (&blk_sleep)));

  // R4: one global line
  a_r4_gwl_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ##1 ($countones(gwl) == 1));

  // R5: the addressed row fires
  a_r5_row_match: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ##1 lwl[$past(row_addr, 2)]);

  // R6: exactly one block awake
  a_r6_one_awake: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ##1 ($countones(blk_sleep) == NUM_BLK - 1));

  // R8: never two local lines at once
  a_r8_single_lwl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lwl) <= 1);

  // R7: sleeping blocks stay dark
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    a_r7_dark_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      blk_sleep[b] |-> (lwl[b*RPB +: RPB] == '0));
  end

endmodule

bind row_decoder_hier row_decoder_hier_chk #(.ADDR_W(ADDR_W), .BLK_PAIRS(BLK_PAIRS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .row_addr  (row_addr),
  .pre_lines (pre_lines),
  .gwl       (gwl),
  .lwl       (lwl),
  .blk_sleep (blk_sleep)
);

// File: tb/tb_row_decoder_hier.sv
module tb_row_decoder_hier;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 10;
  localparam int NGRP    = 5;
  localparam int PRE_W   = 20;
  localparam int NGWL    = 64;
  localparam int NUM_BLK = 4;
  localparam int NROWS   = 1024;
  localparam int RPB     = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [ADDR_W-1:0] row_addr = '0;
  logic [PRE_W-1:0]  pre_lines;
  logic [NGWL-1:0]   gwl;
  logic [NROWS-1:0]  lwl;
  logic [NUM_BLK-1:0] blk_sleep;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // Stimulus history: 1 = previous negedge, 2 = one before.
  logic h1_en = 1'b0, h2_en = 1'b0;
  logic [ADDR_W-1:0] h1_a = '0, h2_a = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_decoder_hier dut (
    .clk(clk), .rst_n(rst_n), .en(en), .row_addr(row_addr),
    .pre_lines(pre_lines), .gwl(gwl), .lwl(lwl), .blk_sleep(blk_sleep)
  );

  function automatic logic [PRE_W-1:0] exp_pre(input logic e, input logic [ADDR_W-1:0] a);
    logic [PRE_W-1:0] r = '0;
    if (e) for (int g = 0; g < NGRP; g++) r[4*g + int'(a[2*g +: 2])] = 1'b1;
    return r;
  endfunction

  function automatic logic [NGWL-1:0] exp_gwl(input logic e, input logic [ADDR_W-1:0] a);
    logic [NGWL-1:0] r = '0;
    if (e) r[a[7:2]] = 1'b1;
    return r;
  endfunction

  function automatic logic [NROWS-1:0] exp_lwl(input logic e, input logic [ADDR_W-1:0] a);
    logic [NROWS-1:0] r = '0;
    if (e) r[a] = 1'b1;
    return r;
  endfunction

  function automatic logic [NUM_BLK-1:0] exp_sleep(input logic e, input logic [ADDR_W-1:0] a);
    logic [NUM_BLK-1:0] r = '1;
    if (e) r[a[9:8]] = 1'b0;
    return r;
  endfunction

  function automatic int first_set(input logic [NROWS-1:0] v);
    for (int i = 0; i < NROWS; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check_outputs();
    logic [PRE_W-1:0]   ep;
    logic [NGWL-1:0]    eg;
    logic [NROWS-1:0]   el;
    logic [NUM_BLK-1:0] es;
    ep = exp_pre(h1_en, h1_a);
    eg = exp_gwl(h2_en, h2_a);
    el = exp_lwl(h2_en, h2_a);
    es = exp_sleep(h2_en, h2_a);
    n_checks++;
    if (pre_lines !== ep) begin
      n_fail++;
      $display("FAIL %s pre_lines actual %h expected %h", h1_en ? "R2" : "R3", pre_lines, ep);
    end
    n_checks++;
    if (gwl !== eg) begin
      n_fail++;
      $display("FAIL %s gwl actual %h expected %h", h2_en ? "R4" : "R3", gwl, eg);
    end
    n_checks++;
    if (lwl !== el) begin
      n_fail++;
      $display("FAIL R5,R8 lwl actual count %0d first %0d expected count %0d index %0d",
               $countones(lwl), first_set(lwl), h2_en ? 1 : 0, h2_en ? int'(h2_a) : -1);
    end
    n_checks++;
    if (blk_sleep !== es) begin
      n_fail++;
      $display("FAIL R6 blk_sleep actual %b expected %b", blk_sleep, es);
    end
    // R7: no active row in a sleeping block
    for (int b = 0; b < NUM_BLK; b++) begin
      n_checks++;
      if (blk_sleep[b] && (lwl[b*RPB +: RPB] != '0)) begin
        n_fail++;
        $display("FAIL R7 block %0d asleep with %0d active rows, expected 0",
                 b, $countones(lwl[b*RPB +: RPB]));
      end
    end
  endtask

  // One cycle: check at negedge, then drive the next input.
  task automatic step(input logic e, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    check_outputs();
    en = e;
    row_addr = a;
    h2_en = h1_en; h2_a = h1_a;
    h1_en = e;     h1_a = a;
  endtask

  initial begin
    int unused_seed;
    unused_seed = int'($urandom(32'h5EED_2024));
    // R1: reset state
    repeat (3) @(negedge clk);
    en = 1'b1; row_addr = 10'h155;
    @(negedge clk);
    n_checks++;
    if (pre_lines !== '0 || gwl !== '0 || lwl !== '0 || blk_sleep !== '1) begin
      n_fail++;
      $display("FAIL R1 reset pre %h gwl %h lwl count %0d sleep %b expected all 0 and sleep 1111",
               pre_lines, gwl, $countones(lwl), blk_sleep);
    end
    en = 1'b0;
    rst_n = 1'b1;
    // Directed corners: block edges, extremes, back-to-back (R8)
    step(1'b1, 10'd0);
    step(1'b1, 10'd1023);
    step(1'b1, 10'd255);
    step(1'b1, 10'd256);
    step(1'b1, 10'd511);
    step(1'b1, 10'd512);
    step(1'b1, 10'd767);
    step(1'b1, 10'd768);
    // R3: enable drop mid-stream, single and double
    step(1'b0, 10'd300);
    step(1'b1, 10'd3);
    step(1'b0, 10'd3);
    step(1'b0, 10'd700);
    step(1'b1, 10'h2AA);
    step(1'b1, 10'h155);
    // Same address twice
    step(1'b1, 10'h155);
    // Walk every row once per block boundary pattern
    for (int i = 0; i < 1024; i++) step(1'b1, 10'(i));
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic e;
      e = ($urandom % 8) != 0;
      step(e, 10'($urandom));
    end
    step(1'b0, 10'd0);
    step(1'b0, 10'd0);
    step(1'b0, 10'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule